// File: doc/BRIEF.md
# Prescaled Up-Counter with Selectable Reload Alignment

This block is a free-running up-counter whose advance rate comes from a programmable prescaler. A 3-bit division code picks one of eight ratios between 1 and 1024, and a 2-bit width code makes the counter behave as an 8-, 16- or 32-bit register. The counter wraps to zero past the top of the chosen width and flags the wrap with a one-cycle pulse.

A reload request clears the count. A 2-bit alignment code decides when that happens: at the next base clock edge, at the next prescaler tick, or at the next base clock edge with the prescaler phase also cleared. The division, width and alignment codes are sampled only while the counter is disabled, so software sets them up first and then enables the block.

Top module: `pscnt_top`

## Requirements
- R1: After reset, `count_o` is 0, `ovf_o` is 0 and `tick_o` is 0.
- R2: The division code maps to these ratios: 0→1, 1→2, 2→4, 3→8, 4→16, 5→64, 6→256, 7→1024. While enabled, `tick_o` is high in one cycle out of every ratio cycles. The first tick falls in enabled cycle ratio−1, counting the first enabled cycle as 0. With code 0, `tick_o` is high in every enabled cycle.
- R3: Each cycle with `tick_o` high and no reload taking effect raises `count_o` by one at the next clock edge. Without a tick, the count holds.
- R4: The width code selects the counter width: 0 = 16 bits, 1 = 8 bits, 2 = 32 bits. Code 3 behaves as code 0. A tick at the width's maximum value wraps the count to 0.
- R5: `ovf_o` is high for exactly the one cycle after a wrap edge. In that cycle `count_o` reads 0.
- R6: With alignment code 0, a cycle with `reload_i` high clears the count at the next clock edge, and the prescaler phase carries on. Code 3 behaves as code 0.
- R7: With alignment code 1, a reload request is held until the next prescaler tick. At that tick the count becomes 0 and does not increment.
- R8: With alignment code 2, a reload request clears the count and the prescaler phase at the next clock edge. The next tick then comes a full ratio later.
- R9: The division, width and alignment codes are captured only in cycles where `enable_i` is low. Changes made while enabled have no effect.
- R10: While `enable_i` is low, the count is 0, `tick_o` is low, and the prescaler phase and any held reload request are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; configuration is captured while low |
| div_sel_i | input | 3 | Division code |
| width_sel_i | input | 2 | Counter width code |
| sync_sel_i | input | 2 | Reload alignment code |
| reload_i | input | 1 | Reload (clear) request, one cycle per request |
| count_o | output | CNT_W | Current count value |
| ovf_o | output | 1 | One-cycle wrap pulse |
| tick_o | output | 1 | Prescaler tick |

## Verification
The assertions assume that `reload_i` is treated as a single-cycle request. They also assume the configuration codes only matter through what the block captured while disabled, so the configuration register may not move in any cycle after an enabled one. The stimulus respects this in several ways. It changes the codes only with the block disabled, with one exception: the deliberate R9 test, which checks that a change made while enabled does not take hold. It holds the block disabled for at least one edge before each enable. It pulses `reload_i` for exactly one cycle, at a prescaler phase chosen to be away from a tick, so the three alignment codes give distinguishable results.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;

    typedef enum logic [1:0] {
        WID_16  = 2'd0,
        WID_8   = 2'd1,
        WID_32  = 2'd2,
        WID_RSV = 2'd3
    } width_e;

    typedef enum logic [1:0] {
        ALN_BASE   = 2'd0,
        ALN_TICK   = 2'd1,
        ALN_RESYNC = 2'd2,
        ALN_RSV    = 2'd3
    } align_e;

    typedef struct packed {
        logic [2:0] div;
        width_e     width;
        align_e     align;
    } cfg_t;

    // log2 of the division ratio; ratios 32 and 128 are not offered
    function automatic logic [3:0] div_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd0;
            3'd1:    return 4'd1;
            3'd2:    return 4'd2;
            3'd3:    return 4'd3;
            3'd4:    return 4'd4;
            3'd5:    return 4'd6;
            3'd6:    return 4'd8;
            default: return 4'd10;
        endcase
    endfunction

    function automatic int unsigned width_bits(input width_e w);
        case (w)
            WID_8:   return 8;
            WID_32:  return 32;
            default: return 16;
        endcase
    endfunction

    // reserved codes fold onto code 0
    function automatic cfg_t legalize(input logic [2:0] d, input logic [1:0] w, input logic [1:0] s);
        cfg_t c;
        c.div   = d;
        c.width = (w == 2'd3) ? WID_16 : width_e'(w);
        c.align = (s == 2'd3) ? ALN_BASE : align_e'(s);
        return c;
    endfunction

endpackage

// File: rtl/pscnt_prescaler.sv
module pscnt_prescaler
    import pscnt_pkg::*;
#(
    parameter int PSC_W = 10
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic [2:0] div_i,
    input  logic       clear_i,
    output logic       tick_o
);

    localparam int EXT_W = PSC_W + 1;

    logic [PSC_W-1:0] phase_d, phase_q;
    logic [EXT_W-1:0] lim_ext;
    logic [PSC_W-1:0] lim;

    always_comb begin
        lim_ext = (EXT_W'(1) << div_shift(div_i)) - EXT_W'(1);
        lim     = lim_ext[PSC_W-1:0];
        tick_o  = enable_i && (phase_q == lim);
        if (!enable_i || clear_i || tick_o) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + PSC_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    // R10: a disabled cycle leaves the phase at zero
    p_phase_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (phase_q == '0));

    // R2: the phase never passes the limit of the selected ratio
    p_phase_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enable_i |-> (phase_q <= lim));

endmodule

// File: rtl/pscnt_counter.sv
module pscnt_counter
    import pscnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  width_e           width_i,
    input  align_e           align_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             presc_clr_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic             pend;
    } st_t;

    st_t         st_d, st_q;
    logic [CNT_W-1:0] max_val;
    logic        at_tick_mode;
    logic        pend_now;

    always_comb begin
        max_val      = {CNT_W{1'b1}} >> (CNT_W - width_bits(width_i));
        at_tick_mode = (align_i == ALN_TICK);
        pend_now     = st_q.pend || (reload_i && at_tick_mode);
        st_d         = st_q;
        st_d.ovf     = 1'b0;
        presc_clr_o  = 1'b0;
        if (!enable_i) begin
            st_d.count = '0;
            st_d.pend  = 1'b0;
        end else if (reload_i && !at_tick_mode) begin
            st_d.count  = '0;
            st_d.pend   = 1'b0;
            presc_clr_o = (align_i == ALN_RESYNC);
        end else begin
            st_d.pend = pend_now;
            if (tick_i) begin
                if (pend_now) begin
                    st_d.count = '0;
                    st_d.pend  = 1'b0;
                end else if (st_q.count == max_val) begin
                    st_d.count = '0;
                    st_d.ovf   = 1'b1;
                end else begin
                    st_d.count = st_q.count + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign ovf_o   = st_q.ovf;

    // R3: a plain tick below the top steps the count by one
    p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && tick_i && !reload_i && !st_q.pend && (st_q.count != max_val))
        |=> (st_q.count == $past(st_q.count) + CNT_W'(1)));

    // R3: no tick and no reload means the count holds
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !tick_i && !reload_i) |=> $stable(st_q.count));

    // R5: the wrap pulse coincides with a zero count
    p_ovf_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ovf |-> (st_q.count == '0));

    // R5: the wrap pulse lasts one cycle
    p_ovf_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ovf |=> !st_q.ovf);

    // R7: a held request never outlives a disabled cycle
    p_pend_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !st_q.pend);

endmodule

// File: rtl/pscnt_top.sv
module pscnt_top
    import pscnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [2:0]       div_sel_i,
    input  logic [1:0]       width_sel_i,
    input  logic [1:0]       sync_sel_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             tick_o
);

    cfg_t cfg_d, cfg_q;
    logic presc_clr;
    logic tick;

    always_comb begin
        cfg_d = enable_i ? cfg_q : legalize(div_sel_i, width_sel_i, sync_sel_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    pscnt_prescaler #(.PSC_W(PSC_W)) u_presc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (enable_i),
        .div_i    (cfg_q.div),
        .clear_i  (presc_clr),
        .tick_o   (tick)
    );

    pscnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .enable_i    (enable_i),
        .tick_i      (tick),
        .reload_i    (reload_i),
        .width_i     (cfg_q.width),
        .align_i     (cfg_q.align),
        .count_o     (count_o),
        .ovf_o       (ovf_o),
        .presc_clr_o (presc_clr)
    );

    assign tick_o = tick;

    // R9: configuration is frozen after any enabled cycle
    p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enable_i |=> $stable(cfg_q));

    // R10: no tick while disabled
    p_no_tick_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !tick_o);

endmodule

// File: tb/pscnt_top_tb.sv
`timescale 1ns/1ps
module pscnt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  div_sel = '0;
    logic [1:0]  width_sel = '0;
    logic [1:0]  sync_sel = '0;
    logic        reload = 1'b0;
    logic [31:0] count;
    logic        ovf;
    logic        tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pscnt_top dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .enable_i    (enable),
        .div_sel_i   (div_sel),
        .width_sel_i (width_sel),
        .sync_sel_i  (sync_sel),
        .reload_i    (reload),
        .count_o     (count),
        .ovf_o       (ovf),
        .tick_o      (tick)
    );

    typedef struct packed {
        logic [2:0]  div;
        logic [1:0]  wid;
        logic [19:0] edges;
        logic [31:0] exp;
    } vec_t;

    // enabled edges and expected count = (edges / ratio) mod 2^width
    localparam vec_t VECS [12] = '{
        '{3'd0, 2'd0, 20'd10,    32'd10},
        '{3'd1, 2'd0, 20'd10,    32'd5},
        '{3'd2, 2'd1, 20'd9,     32'd2},
        '{3'd3, 2'd0, 20'd20,    32'd2},
        '{3'd4, 2'd0, 20'd50,    32'd3},
        '{3'd5, 2'd0, 20'd200,   32'd3},
        '{3'd6, 2'd2, 20'd600,   32'd2},
        '{3'd7, 2'd0, 20'd2100,  32'd2},
        '{3'd0, 2'd1, 20'd300,   32'd44},
        '{3'd1, 2'd1, 20'd600,   32'd44},
        '{3'd0, 2'd3, 20'd70000, 32'd4464},
        '{3'd0, 2'd2, 20'd70000, 32'd70000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // disable, load codes for one edge, then enable; returns at cycle 0
    task automatic setup(input logic [2:0] d, input logic [1:0] w, input logic [1:0] s);
        @(negedge clk);
        enable = 1'b0;
        div_sel = d;
        width_sel = w;
        sync_sel = s;
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reload in cycle 43 at ratio 8, then probe count
    task automatic reload_case(input logic [1:0] s, input int e1, input logic [31:0] x1,
                               input int e2, input logic [31:0] x2, input string req);
        setup(3'd3, 2'd0, s);
        edges(43);
        #1 chk(req, count, 32'd5);
        reload = 1'b1;
        edges(1);
        reload = 1'b0;
        edges(e1);
        #1 chk(req, count, x1);
        edges(e2);
        #1 chk(req, count, x2);
    endtask

    initial begin
        #(195000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        edges(3);
        #1;
        chk("R1 count", count, 32'd0);
        chk("R1 ovf", {31'd0, ovf}, 32'd0);
        chk("R1 tick", {31'd0, tick}, 32'd0);
        rst_n = 1'b1;

        // R2 R3 R4 table walk over ratios and widths
        for (int i = 0; i < 12; i++) begin
            setup(VECS[i].div, VECS[i].wid, 2'd0);
            edges(int'(VECS[i].edges));
            #1 chk("R2 R3 R4 table", count, VECS[i].exp);
        end

        // R2 tick pattern at ratio 4: high in cycles 3 and 7
        setup(3'd2, 2'd0, 2'd0);
        for (int j = 0; j < 8; j++) begin
            #1 chk("R2 tick ratio 4", {31'd0, tick}, {31'd0, (j % 4) == 3});
            @(negedge clk);
        end
        // R2 ratio 1 ticks every cycle
        setup(3'd0, 2'd0, 2'd0);
        #1 chk("R2 tick ratio 1", {31'd0, tick}, 32'd1);

        // R4 R5 8-bit wrap and overflow pulse
        setup(3'd0, 2'd1, 2'd0);
        edges(255);
        #1 chk("R4 at max", count, 32'd255);
        chk("R5 no pulse before wrap", {31'd0, ovf}, 32'd0);
        edges(1);
        #1 chk("R4 wrapped", count, 32'd0);
        chk("R5 pulse", {31'd0, ovf}, 32'd1);
        edges(1);
        #1 chk("R5 pulse ends", {31'd0, ovf}, 32'd0);
        chk("R5 count after", count, 32'd1);

        // R6 base-clock reload keeps prescaler phase
        reload_case(2'd0, 3, 32'd0, 1, 32'd1, "R6 base");
        // R6 reserved code acts as code 0
        reload_case(2'd3, 3, 32'd0, 1, 32'd1, "R6 reserved");
        // R7 reload waits for the tick
        reload_case(2'd1, 3, 32'd5, 1, 32'd0, "R7 tick aligned");
        edges(8);
        #1 chk("R7 counting resumes", count, 32'd1);
        // R8 reload also clears prescaler phase
        reload_case(2'd2, 7, 32'd0, 1, 32'd1, "R8 resync");

        // R9 code changes while enabled are ignored
        setup(3'd0, 2'd0, 2'd0);
        edges(3);
        div_sel = 3'd7;
        width_sel = 2'd1;
        edges(300);
        #1 chk("R9 config held", count, 32'd303);

        // R10 disabled: count zero, tick low
        enable = 1'b0;
        edges(1);
        #1;
        chk("R10 count idle", count, 32'd0);
        chk("R10 tick idle", {31'd0, tick}, 32'd0);

        // R10 held request dropped by a disabled cycle
        setup(3'd1, 2'd0, 2'd1);
        reload = 1'b1;
        edges(1);
        reload = 1'b0;
        enable = 1'b0;
        edges(1);
        enable = 1'b1;
        edges(4);
        #1 chk("R10 pending cleared", count, 32'd2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule